// File: doc/BRIEF.md
# DMA Channel Bus-Mode Sequencer

This block sequences one DMA channel on a shared system bus. It decides when the channel asks the CPU for the bus, when it runs bus cycles and when it hands the bus back. Each transfer is dual-address: a one-clock read strobe at the source address, then a one-clock write strobe at the destination address. A transfer counter, loaded at start, runs down to a terminal count. The channel then stops and gives a one-clock end pulse.

A start pulse latches the configuration. This holds the count, both addresses, the per-address step-or-hold choice, the bus mode, the gap length and the request source. A request comes either from an active-low external pin, which is synchronised before it is used, or from a peripheral request line tagged with a peripheral id.

There are two bus modes. In intermittent cycle-steal mode the bus is handed back after every transfer, and the next read waits for a programmed gap of 16 or 64 clocks. In burst mode transfers follow each other until the count ends. With the external pin as the source, a burst ends early when the pin goes inactive, and it resumes when the pin returns. Only some peripheral ids may use burst mode. Any other id falls back to intermittent mode.

Top module: `dma_busmode_seq`

## Requirements
- R1: After reset, bus_req, rd_stb, wr_stb, tc_pulse and ch_active are 0 and count_left is 0.
- R2: A start pulse while ch_active is 0 and cfg_count is nonzero loads the count, which shows on count_left, and sets ch_active on the next clock. A start with cfg_count equal to 0 is ignored: ch_active stays 0 and bus_req stays 0 even with a request present.
- R3: bus_req rises only while the channel is active and a request is present. Once raised, it stays high until bus_gnt is seen. No rd_stb occurs unless bus_gnt was high in the clock before.
- R4: Each transfer is one clock of rd_stb with bus_addr equal to the source address, followed in the next clock by one clock of wr_stb with bus_addr equal to the destination address. rd_stb and wr_stb are never high together.
- R5: count_left drops by one after each write. The final write happens with bus_req low. tc_pulse is high for exactly the one clock after the final write, and ch_active is 0 from that clock on.
- R6: After each transfer the source address advances by 4 (the transfer size) when cfg_src_inc is 1 and holds when it is 0. The destination address does the same under cfg_dst_inc.
- R7: In intermittent mode (cfg_burst 0) bus_req is low during every write. The next rd_stb comes at least 17 clocks after the previous wr_stb when cfg_gap_long is 0, and at least 65 clocks after it when cfg_gap_long is 1. A request that stays present through the gap is served after the gap.
- R8: In burst mode with a burst-capable source and the request held, bus_req stays high through every non-final write, and each non-final wr_stb is followed in the next clock by rd_stb.
- R9: In burst mode with the external source (cfg_ext_src 1), driving ext_req_n high lets the transfers already accepted finish. The block then drops bus_req with ch_active still 1 and count_left nonzero, and runs no rd_stb until ext_req_n goes low again. It then completes the remaining count.
- R10: With the peripheral source (cfg_ext_src 0), burst mode applies only to peripheral ids 0 to 4. For ids 5 to 7 the block behaves as in R7.
- R11: ext_req_n passes through a two-flop synchroniser. After ext_req_n falls between clock edges, bus_req is still low after the second rising edge and is high after the third, provided the channel is active and no gap is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-clock pulse that latches the configuration and arms the channel |
| cfg_count | input | 8 | Number of transfers |
| cfg_src | input | 16 | Initial source address |
| cfg_dst | input | 16 | Initial destination address |
| cfg_src_inc | input | 1 | 1: source address advances by the transfer size; 0: held |
| cfg_dst_inc | input | 1 | 1: destination address advances by the transfer size; 0: held |
| cfg_burst | input | 1 | 1: burst mode requested; 0: intermittent cycle-steal mode |
| cfg_gap_long | input | 1 | Intermittent gap: 0 gives 16 clocks, 1 gives 64 clocks |
| cfg_ext_src | input | 1 | 1: request from ext_req_n; 0: request from periph_req |
| cfg_periph_id | input | 3 | Id of the peripheral request source |
| ext_req_n | input | 1 | External request, active low, asynchronous level |
| periph_req | input | 1 | Peripheral request, active-high level |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_req | output | 1 | Bus request to the arbiter |
| rd_stb | output | 1 | Read cycle strobe |
| wr_stb | output | 1 | Write cycle strobe |
| bus_addr | output | 16 | Address of the current bus cycle |
| tc_pulse | output | 1 | One-clock terminal-count pulse |
| ch_active | output | 1 | Channel enabled |
| count_left | output | 8 | Transfers remaining |

## Verification
A wrong sequencer state shows at the ports within one or two clocks in most cases. It appears as a write without its read, as a read without a prior grant, as bus_req high during an intermittent or final write, or as a wrong address on bus_addr at the next strobe. A broken gap counter appears only at the next read, up to 65 clocks later, as a read that comes too early. A stuck counter shows one transfer late, as an early, late or missing tc_pulse. Errors in the burst-capability decode or in the synchroniser show up as back-to-back reads where gaps were due (or the reverse), or as bus_req rising a clock early or late after the pin falls.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES > 1) begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], async_in};
        end else begin : g_single
            always_comb sh_d = async_in;
        end
    endgenerate

    // reset to the inactive (high) level of the active-low pin
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign sync_out = sh_q[STAGES-1];
endmodule

// File: rtl/dma_gap_timer.sv
module dma_gap_timer #(
    parameter int GAP_SHORT = 16,
    parameter int GAP_LONG  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic long_sel,
    output logic busy
);
    localparam int GW = $clog2(GAP_LONG + 1);
    localparam logic [GW-1:0] SHORT_V = GW'(GAP_SHORT);
    localparam logic [GW-1:0] LONG_V  = GW'(GAP_LONG);

    logic [GW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = long_sel ? LONG_V : SHORT_V;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/dma_busmode_seq.sv
module dma_busmode_seq
    import dma_seq_pkg::*;
#(
    parameter int AW          = 16,
    parameter int CW          = 8,
    parameter int XFER_BYTES  = 4,
    parameter int NUM_PERIPH  = 8,
    parameter logic [NUM_PERIPH-1:0] BURST_MASK = 8'h1F,
    parameter int GAP_SHORT   = 16,
    parameter int GAP_LONG    = 64,
    parameter int SYNC_STAGES = 2,
    localparam int PID_W = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CW-1:0]    cfg_count,
    input  logic [AW-1:0]    cfg_src,
    input  logic [AW-1:0]    cfg_dst,
    input  logic             cfg_src_inc,
    input  logic             cfg_dst_inc,
    input  logic             cfg_burst,
    input  logic             cfg_gap_long,
    input  logic             cfg_ext_src,
    input  logic [PID_W-1:0] cfg_periph_id,
    input  logic             ext_req_n,
    input  logic             periph_req,
    input  logic             bus_gnt,
    output logic             bus_req,
    output logic             rd_stb,
    output logic             wr_stb,
    output logic [AW-1:0]    bus_addr,
    output logic             tc_pulse,
    output logic             ch_active,
    output logic [CW-1:0]    count_left
);
    localparam logic [AW-1:0] STEP = AW'(XFER_BYTES);

    typedef struct packed {
        seq_state_e    st;
        logic          active;
        logic [CW-1:0] cnt;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic          src_inc;
        logic          dst_inc;
        logic          burst;
        logic          gap_long;
        logic          ext;
        logic          tc;
    } seq_t;

    seq_t s_d, s_q;
    logic ext_sync_n, req_active, gap_busy, gap_load;
    logic last_xfer, keep_bus, burst_ok;

    dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_req_n),
        .sync_out (ext_sync_n)
    );

    dma_gap_timer #(.GAP_SHORT(GAP_SHORT), .GAP_LONG(GAP_LONG)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .long_sel (s_q.gap_long),
        .busy     (gap_busy)
    );

    // Request level from the selected source
    assign req_active = s_q.ext ? ~ext_sync_n : periph_req;
    // Burst is kept only for the external pin or a burst-capable peripheral
    assign burst_ok   = cfg_burst & (cfg_ext_src | BURST_MASK[cfg_periph_id]);
    assign last_xfer  = (s_q.cnt == CW'(1));
    // Hold the bus past this write: burst, not last, pin still asserted
    assign keep_bus   = s_q.burst & ~last_xfer & (~s_q.ext | req_active);

    always_comb begin
        s_d      = s_q;
        s_d.tc   = 1'b0;
        gap_load = 1'b0;
        if (start && !s_q.active && cfg_count != '0) begin
            s_d.active   = 1'b1;
            s_d.cnt      = cfg_count;
            s_d.src      = cfg_src;
            s_d.dst      = cfg_dst;
            s_d.src_inc  = cfg_src_inc;
            s_d.dst_inc  = cfg_dst_inc;
            s_d.burst    = burst_ok;
            s_d.gap_long = cfg_gap_long;
            s_d.ext      = cfg_ext_src;
        end
        unique case (s_q.st)
            ST_IDLE: if (s_q.active && req_active && !gap_busy) s_d.st = ST_REQ;
            ST_REQ:  if (bus_gnt) s_d.st = ST_RD;
            ST_RD:   s_d.st = ST_WR;
            ST_WR: begin
                s_d.cnt = s_q.cnt - 1'b1;
                if (s_q.src_inc) s_d.src = s_q.src + STEP;
                if (s_q.dst_inc) s_d.dst = s_q.dst + STEP;
                if (last_xfer) begin
                    s_d.active = 1'b0;
                    s_d.tc     = 1'b1;
                end
                if (keep_bus) begin
                    s_d.st = bus_gnt ? ST_RD : ST_REQ;
                end else begin
                    s_d.st   = ST_IDLE;
                    gap_load = ~s_q.burst;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_stb     = (s_q.st == ST_RD);
    assign wr_stb     = (s_q.st == ST_WR);
    assign bus_req    = (s_q.st == ST_REQ) || (s_q.st == ST_RD) ||
                        ((s_q.st == ST_WR) && keep_bus);
    assign bus_addr   = (s_q.st == ST_WR) ? s_q.dst : s_q.src;
    assign tc_pulse   = s_q.tc;
    assign ch_active  = s_q.active;
    assign count_left = s_q.cnt;
endmodule

// File: rtl/dma_busmode_seq_chk.sv
module dma_busmode_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_req,
    input logic bus_gnt,
    input logic rd_stb,
    input logic wr_stb,
    input logic tc_pulse,
    input logic ch_active
);
    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb)); // R4
    AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> wr_stb); // R4
    AST_RD_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> $past(bus_gnt)); // R3
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !rd_stb && !wr_stb) |=> bus_req); // R3
    AST_TC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> !tc_pulse); // R5
    AST_TC_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> ($past(wr_stb) && !ch_active)); // R5
    AST_TC_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> $past(!bus_req)); // R5
endmodule

bind dma_busmode_seq dma_busmode_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .tc_pulse  (tc_pulse),
    .ch_active (ch_active)
);

// File: tb/dma_busmode_seq_bench.sv
`timescale 1ns/1ps
module dma_busmode_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  cfg_count = '0;
    logic [15:0] cfg_src = '0, cfg_dst = '0;
    logic        cfg_src_inc = 1'b0, cfg_dst_inc = 1'b0, cfg_burst = 1'b0;
    logic        cfg_gap_long = 1'b0, cfg_ext_src = 1'b0;
    logic [2:0]  cfg_periph_id = '0;
    logic        ext_req_n = 1'b1, periph_req = 1'b0, bus_gnt = 1'b0;
    logic        bus_req, rd_stb, wr_stb, tc_pulse, ch_active;
    logic [15:0] bus_addr;
    logic [7:0]  count_left;

    always #2.5 clk = ~clk;

    dma_busmode_seq u_dma_busmode_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_count(cfg_count),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_src_inc(cfg_src_inc),
        .cfg_dst_inc(cfg_dst_inc), .cfg_burst(cfg_burst),
        .cfg_gap_long(cfg_gap_long), .cfg_ext_src(cfg_ext_src),
        .cfg_periph_id(cfg_periph_id), .ext_req_n(ext_req_n),
        .periph_req(periph_req), .bus_gnt(bus_gnt), .bus_req(bus_req),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .bus_addr(bus_addr),
        .tc_pulse(tc_pulse), .ch_active(ch_active), .count_left(count_left)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int cyc = 0;
    int gnt_lat = 0;

    // monitor model state
    bit          mon_en = 0;
    int          m_count, m_gap, n_x, last_wr, last_rd, expect_rd_at, tc_cnt;
    bit          m_beff, m_si, m_di, chk_b2b, have_wr;
    logic [15:0] e_src, e_dst;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit burst_eff(input bit b, input bit ext, input int pid);
        return b && (ext || pid <= 4);
    endfunction

    function automatic int gap_of(input bit g64);
        return g64 ? 64 : 16;
    endfunction

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // grant model: grants after gnt_lat extra edges of a held request
    initial begin : grant_model
        int hc;
        hc = 0;
        forever begin
            @(posedge clk);
            if (!bus_req) begin
                hc = 0;
                bus_gnt <= 1'b0;
            end else if (hc >= gnt_lat) begin
                bus_gnt <= 1'b1;
            end else begin
                hc++;
            end
        end
    end

    // transfer monitor, sampling between edges
    initial forever begin
        @(negedge clk);
        if (mon_en) begin
            if (expect_rd_at == cyc) begin
                chk(rd_stb, "R8", "rd right after burst write", rd_stb, 1);
                expect_rd_at = -1;
            end
            if (rd_stb) begin
                chk(bus_addr == e_src, "R6", "read address", bus_addr, e_src);
                if (!m_beff && have_wr)
                    chk(cyc - last_wr >= m_gap + 1, "R7", "intermittent gap",
                        cyc - last_wr, m_gap + 1);
                last_rd = cyc;
            end
            if (wr_stb) begin
                chk(cyc == last_rd + 1, "R4", "write follows read", cyc, last_rd + 1);
                chk(bus_addr == e_dst, "R6", "write address", bus_addr, e_dst);
                n_x++;
                if (n_x == m_count)
                    chk(!bus_req, "R5", "bus_req low on final write", bus_req, 0);
                else if (!m_beff)
                    chk(!bus_req, "R7", "bus_req low on write", bus_req, 0);
                else if (chk_b2b) begin
                    chk(bus_req, "R8", "bus held in burst", bus_req, 1);
                    expect_rd_at = cyc + 1;
                end
                if (m_si) e_src = e_src + 16'd4;
                if (m_di) e_dst = e_dst + 16'd4;
                last_wr = cyc;
                have_wr = 1;
            end
            if (tc_pulse) begin
                chk(cyc == last_wr + 1 && n_x == m_count, "R5", "tc after final write",
                    n_x, m_count);
                tc_cnt++;
            end
        end
    end

    // probe: 0 none, 1 synchroniser timing, 2 grant hold, 3 burst withdrawal
    task automatic run(input int cnt, input bit b, input bit g64, input bit ext,
                       input int pid, input bit si, input bit di,
                       input logic [15:0] s, input logic [15:0] d, input int probe);
        int t;
        int nsave;
        @(negedge clk);
        cfg_count = 8'(cnt); cfg_burst = b; cfg_gap_long = g64; cfg_ext_src = ext;
        cfg_periph_id = 3'(pid); cfg_src_inc = si; cfg_dst_inc = di;
        cfg_src = s; cfg_dst = d;
        m_count = cnt; m_beff = burst_eff(b, ext, pid); m_gap = gap_of(g64);
        m_si = si; m_di = di; e_src = s; e_dst = d;
        chk_b2b = m_beff && (probe != 3);
        n_x = 0; have_wr = 0; tc_cnt = 0; expect_rd_at = -1; last_rd = -10; last_wr = -10;
        mon_en = 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(ch_active && count_left == 8'(cnt), "R2", "start loads count", count_left, cnt);
        if (ext) ext_req_n = 1'b0; else periph_req = 1'b1;
        if (probe == 1) begin
            @(negedge clk);
            chk(!bus_req, "R11", "bus_req after 1 edge", bus_req, 0);
            @(negedge clk);
            chk(!bus_req, "R11", "bus_req after 2 edges", bus_req, 0);
            @(negedge clk);
            chk(bus_req, "R11", "bus_req after 3 edges", bus_req, 1);
        end
        if (probe == 2) begin
            t = 0;
            while (!bus_req && t < 20) begin @(negedge clk); t++; end
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                chk(bus_req && !rd_stb, "R3", "request held awaiting grant", bus_req, 1);
            end
        end
        if (probe == 3) begin
            t = 0;
            while (n_x < 2 && t < 100) begin @(negedge clk); t++; end
            ext_req_n = 1'b1;
            t = 0;
            while (bus_req && t < 20) begin @(negedge clk); t++; end
            chk(!bus_req && ch_active && count_left != 0, "R9", "early release",
                count_left, 1);
            nsave = n_x;
            repeat (12) @(negedge clk);
            chk(n_x == nsave && !bus_req, "R9", "idle while withdrawn", n_x, nsave);
            ext_req_n = 1'b0;
        end
        t = 0;
        while (tc_cnt == 0 && t < 3000) begin @(negedge clk); t++; end
        @(negedge clk);
        chk(n_x == cnt, "R5", "transfers done", n_x, cnt);
        chk(tc_cnt == 1, "R5", "single tc pulse", tc_cnt, 1);
        chk(!ch_active && count_left == 0, "R5", "channel off at end", count_left, 0);
        ext_req_n = 1'b1; periph_req = 1'b0;
        mon_en = 0;
        repeat (70) @(negedge clk);
    endtask

    initial begin : main
        int dummy;
        dummy = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req && !rd_stb && !wr_stb && !tc_pulse && !ch_active && count_left == 0,
            "R1", "reset outputs", {bus_req, rd_stb, wr_stb, tc_pulse, ch_active}, 0);

        // R2: zero count start ignored
        cfg_count = 8'd0; cfg_ext_src = 1'b1; ext_req_n = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!ch_active, "R2", "zero count ignored", ch_active, 0);
        repeat (8) @(negedge clk);
        chk(!bus_req, "R2", "no request after zero start", bus_req, 0);
        ext_req_n = 1'b1;
        repeat (4) @(negedge clk);

        run(1, 0, 0, 1, 0, 1, 1, 16'h0100, 16'h0200, 1);         // R11
        run(3, 0, 0, 1, 0, 1, 1, 16'h1000, 16'h2000, 0);         // R7 short gap
        run(3, 0, 1, 0, 6, 0, 0, 16'h3000, 16'h4000, 0);         // R7 long gap, fixed R6
        run(5, 1, 0, 1, 0, 1, 0, 16'h5000, 16'h6000, 0);         // R8
        run(8, 1, 0, 1, 0, 1, 1, 16'h7000, 16'h7800, 3);         // R9
        run(3, 1, 0, 0, 6, 1, 1, 16'h8000, 16'h9000, 0);         // R10 id 6 no burst
        run(4, 1, 1, 0, 2, 0, 1, 16'hA000, 16'hB000, 0);         // R10 id 2 bursts
        gnt_lat = 6;
        run(2, 0, 0, 1, 0, 1, 1, 16'hC000, 16'hD000, 2);         // R3
        for (int i = 0; i < 10; i++) begin
            gnt_lat = int'($urandom % 3);
            run(1 + int'($urandom % 6), 1'($urandom), 1'($urandom), 1'($urandom),
                int'($urandom % 8), 1'($urandom), 1'($urandom),
                16'($urandom), 16'($urandom), 0);
        end
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule